// File: doc/BRIEF.md
# Programmable External Bus Cycle Sequencer

This block turns internal read and write requests into cycles on an external parallel bus. The bus has an address latch enable (ALE), a read strobe and a write strobe. The length of each cycle in clocks comes from an 8-bit timing register that software loads through a simple write port. That register holds four 2-bit length codes:

- read with an ALE phase;
- write with an ALE phase;
- read without an ALE phase;
- write without an ALE phase.

The codes without an ALE phase apply only to the second half of a 16-bit access on an 8-bit bus. That half reuses the latched upper address and starts directly with its strobe.

Requests arrive over a valid/ready handshake. Each request carries an address, write data, a byte/word size flag and a direction flag. The sequencer accepts a request only while it is idle. At acceptance it captures the request, the bus-width mode, the extra-hold enable and the timing register.

When a transfer finishes, the block raises `done` for one clock. For a read, the assembled read data is presented on `rdata` in that same clock. With extra hold enabled, every write byte cycle keeps its address and data driven for one more clock after the write strobe drops.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `bus_ale`, `bus_rd`, `bus_wr`, `bus_doe` and `done` are 0. `bus_addr` and `bus_dout` are 0. The timing register holds 8'hFF, so every length is at its slowest.
- R2: The timing register layout is as follows.
  - Bits 1:0 hold the read-with-ALE code c. A read cycle with an ALE phase lasts c+2 clocks: one ALE clock, then c+1 read-strobe clocks.
  - Bits 3:2 hold the read-without-ALE code.
  - Bits 5:4 hold the write-with-ALE code.
  - Bits 7:6 hold the write-without-ALE code.
- R3: A write cycle with an ALE phase lasts c+2 clocks, where c is bits 5:4: one ALE clock, then c+1 write-strobe clocks with `bus_doe` high.
- R4: In 8-bit mode (`bus16_mode`=0), the second half of a word read follows the first with no ALE clock. Its read strobe lasts c+1 clocks, where c is bits 3:2.
- R5: In 8-bit mode, the second half of a word write lasts c+2 write-strobe clocks with no ALE clock, where c is bits 7:6.
- R6: A word access in 8-bit mode drives the request address with bit 0 forced to 0 in the first half and to 1 in the second half. The low data byte moves first and the high byte second. Both bytes use bus data bits 7:0. `rdata` returns the first byte in bits 7:0 and the second byte in bits 15:8.
- R7: `bus_ale` is high for exactly one clock and is followed directly by a strobe. `bus_rd` and `bus_wr` are never high together.
- R8: When `wr_hold_en` was set at acceptance, each write byte cycle ends with one extra clock. In that clock both strobes are low while `bus_addr`, `bus_dout` and `bus_doe` stay as they were in the strobe clocks.
- R9: `done` is a one-clock pulse in the clock after the last strobe or hold clock of the transfer, and `req_ready` rises in that same clock. `req_ready` is 0 while a transfer is in progress. For reads, `rdata` holds the bus data sampled on the last strobe clock of each byte cycle.
- R10: In 16-bit mode every access is a single ALE cycle, and the without-ALE codes have no effect on it. A word moves on all 16 data bits. A byte access, in either mode, uses bits 7:0 only, and its `rdata` bits 15:8 are 0.
- R11: Changing the timing register while a transfer is in progress does not change that transfer's lengths. The new value applies from the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the timing register |
| cfg_wdata | input | 8 | Timing register value |
| bus16_mode | input | 1 | 1 = 16-bit external bus, 0 = 8-bit |
| wr_hold_en | input | 1 | Add one data hold clock after each write strobe |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, request accepted this clock |
| req_addr | input | AW | Request address |
| req_wdata | input | DATA_W | Request write data |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| done | output | 1 | One-clock transfer completion pulse |
| rdata | output | DATA_W | Assembled read data |
| bus_ale | output | 1 | Address latch enable |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | AW | External address |
| bus_dout | output | DATA_W | External write data |
| bus_doe | output | 1 | Write data drive enable |
| bus_din | input | DATA_W | External read data |

## Verification
The bench builds the block with AW=8 and DATA_W=16. The narrow address lets the external memory model derive read data directly from the 8-bit address, so every byte's expected value is computed from its address alone.

This configuration makes it cheap to sweep every code of every length field:

- all ALE read and write codes in 16-bit mode;
- the full 4x4 cross of ALE and tail codes for split reads;
- the 4x4 cross for split writes, each run with and without extra hold.

Each transfer is compared clock by clock against a trace built arithmetically from the codes. Extra cases cover the reset default timing, odd addresses and a timing-register write during a transfer.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

    // Timing register layout; field positions are fixed by the register map
    typedef struct packed {
        logic [1:0] wr_tail;   // 7:6 write, second half without ALE
        logic [1:0] wr_ale;    // 5:4 write with ALE phase
        logic [1:0] rd_tail;   // 3:2 read, second half without ALE
        logic [1:0] rd_ale;    // 1:0 read with ALE phase
    } bus_timing_t;

    localparam bus_timing_t TIMING_RST = 8'hFF;

    localparam int SPAN_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ALE,
        ST_STB,
        ST_HOLD
    } seq_state_e;

    // Number of strobe clocks for one byte/word cycle.
    // ALE cycles: total length code+2, minus the ALE clock.
    // Tail cycles: read code+1, write code+2.
    function automatic logic [SPAN_W-1:0] strobe_span(
        input bus_timing_t t,
        input logic        is_wr,
        input logic        tail
    );
        logic [1:0]        c;
        logic [SPAN_W-1:0] base;
        if (tail) begin
            c    = is_wr ? t.wr_tail : t.rd_tail;
            base = is_wr ? SPAN_W'(2) : SPAN_W'(1);
        end else begin
            c    = is_wr ? t.wr_ale : t.rd_ale;
            base = SPAN_W'(1);
        end
        return base + SPAN_W'(c);
    endfunction

endpackage

// File: rtl/ebs_timing_reg.sv
module ebs_timing_reg
    import ebs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [7:0]  cfg_wdata,
    output bus_timing_t timing_o
);

    bus_timing_t timing_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            timing_q <= TIMING_RST;
        end else if (cfg_we) begin
            timing_q <= bus_timing_t'(cfg_wdata);
        end
    end

    assign timing_o = timing_q;

endmodule

// File: rtl/ebs_len_sel.sv
module ebs_len_sel
    import ebs_pkg::*;
(
    input  bus_timing_t       timing_i,
    input  logic              is_wr,
    output logic [SPAN_W-1:0] ale_span_o,
    output logic [SPAN_W-1:0] tail_span_o
);

    assign ale_span_o  = strobe_span(timing_i, is_wr, 1'b0);
    assign tail_span_o = strobe_span(timing_i, is_wr, 1'b1);

endmodule

// File: rtl/ebs_seq.sv
module ebs_seq
    import ebs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_word,
    input  logic        req_write,
    input  logic        bus16,
    input  logic        hold_en,
    input  bus_timing_t timing_i,
    output logic        req_ready,
    output logic        accept_o,
    output logic        ale_o,
    output logic        rd_o,
    output logic        wr_o,
    output logic        doe_o,
    output logic        active_o,
    output logic        half_o,
    output logic        split_o,
    output logic        capture_o,
    output logic        done_o
);

    seq_state_e        state_q;
    logic [SPAN_W-1:0] cnt_q;
    logic              half_q;
    logic              wr_q;
    logic              split_q;
    logic              hold_q;
    logic              done_q;
    bus_timing_t       tim_q;

    logic [SPAN_W-1:0] ale_span;
    logic [SPAN_W-1:0] tail_span;
    logic              last_stb;
    logic              end_cyc;
    logic              go_tail;
    logic              go_idle;

    ebs_len_sel u_len (
        .timing_i    (tim_q),
        .is_wr       (wr_q),
        .ale_span_o  (ale_span),
        .tail_span_o (tail_span)
    );

    assign accept_o = req_valid && (state_q == ST_IDLE);
    assign last_stb = (state_q == ST_STB) && (cnt_q == SPAN_W'(1));
    assign end_cyc  = (last_stb && !hold_q) || (state_q == ST_HOLD);
    assign go_tail  = end_cyc && split_q && !half_q;
    assign go_idle  = end_cyc && !go_tail;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            half_q  <= 1'b0;
            wr_q    <= 1'b0;
            split_q <= 1'b0;
            hold_q  <= 1'b0;
            done_q  <= 1'b0;
            tim_q   <= TIMING_RST;
        end else begin
            done_q <= go_idle;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept_o) begin
                        state_q <= ST_ALE;
                        half_q  <= 1'b0;
                        wr_q    <= req_write;
                        split_q <= req_word && !bus16;
                        hold_q  <= hold_en && req_write;
                        tim_q   <= timing_i;
                    end
                end
                ST_ALE: begin
                    state_q <= ST_STB;
                    cnt_q   <= ale_span;
                end
                ST_STB: begin
                    if (last_stb) begin
                        if (hold_q) begin
                            state_q <= ST_HOLD;
                        end else if (go_tail) begin
                            half_q  <= 1'b1;
                            cnt_q   <= tail_span;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end else begin
                        cnt_q <= cnt_q - SPAN_W'(1);
                    end
                end
                ST_HOLD: begin
                    if (go_tail) begin
                        state_q <= ST_STB;
                        half_q  <= 1'b1;
                        cnt_q   <= tail_span;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign ale_o     = (state_q == ST_ALE);
    assign rd_o      = (state_q == ST_STB) && !wr_q;
    assign wr_o      = (state_q == ST_STB) && wr_q;
    assign doe_o     = wr_q && ((state_q == ST_STB) || (state_q == ST_HOLD));
    assign active_o  = (state_q != ST_IDLE);
    assign half_o    = half_q;
    assign split_o   = split_q;
    assign capture_o = last_stb && !wr_q;
    assign done_o    = done_q;

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_o && wr_o));

    // R7
    ale_single_chk: assert property (@(posedge clk) disable iff (rst)
        ale_o |=> (!ale_o && (rd_o || wr_o)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (ale_o || rd_o || wr_o) |-> !req_ready);

    // R8
    hold_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (doe_o && !wr_o) |-> $past(wr_o));

endmodule

// File: rtl/ebs_lane.sv
module ebs_lane #(
    parameter int AW     = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_word,
    input  logic              bus16,
    input  logic              active,
    input  logic              half,
    input  logic              split,
    input  logic              doe,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_din,
    output logic [AW-1:0]     bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic [DATA_W-1:0] rdata
);

    localparam int LANE_W = DATA_W / 2;

    logic [AW-1:0]     addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              wide_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            wide_q  <= 1'b0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            wide_q  <= req_word && bus16;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (capture) begin
            if (wide_q) begin
                rdata_q <= bus_din;
            end else if (half) begin
                rdata_q[DATA_W-1:LANE_W] <= bus_din[LANE_W-1:0];
            end else begin
                rdata_q <= {{LANE_W{1'b0}}, bus_din[LANE_W-1:0]};
            end
        end
    end

    always_comb begin
        bus_addr = '0;
        if (active) begin
            bus_addr = split ? {addr_q[AW-1:1], half} : addr_q;
        end
    end

    always_comb begin
        bus_dout = '0;
        if (doe) begin
            if (wide_q) begin
                bus_dout = wdata_q;
            end else begin
                bus_dout = {{LANE_W{1'b0}},
                            half ? wdata_q[DATA_W-1:LANE_W] : wdata_q[LANE_W-1:0]};
            end
        end
    end

    assign rdata = rdata_q;

    // R6
    tail_addr_odd_chk: assert property (@(posedge clk) disable iff (rst)
        (active && split && half) |-> bus_addr[0]);

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
    import ebs_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    input  logic              bus16_mode,
    input  logic              wr_hold_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_word,
    input  logic              req_write,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_ale,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [AW-1:0]     bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din
);

    bus_timing_t timing;
    logic        accept;
    logic        active;
    logic        half;
    logic        split;
    logic        capture;

    ebs_timing_reg u_treg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .timing_o  (timing)
    );

    ebs_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_word  (req_word),
        .req_write (req_write),
        .bus16     (bus16_mode),
        .hold_en   (wr_hold_en),
        .timing_i  (timing),
        .req_ready (req_ready),
        .accept_o  (accept),
        .ale_o     (bus_ale),
        .rd_o      (bus_rd),
        .wr_o      (bus_wr),
        .doe_o     (bus_doe),
        .active_o  (active),
        .half_o    (half),
        .split_o   (split),
        .capture_o (capture),
        .done_o    (done)
    );

    ebs_lane #(
        .AW     (AW),
        .DATA_W (DATA_W)
    ) u_lane (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_word  (req_word),
        .bus16     (bus16_mode),
        .active    (active),
        .half      (half),
        .split     (split),
        .doe       (bus_doe),
        .capture   (capture),
        .bus_din   (bus_din),
        .bus_addr  (bus_addr),
        .bus_dout  (bus_dout),
        .rdata     (rdata)
    );

endmodule

// File: tb/ext_bus_seq_test.sv
`timescale 1ns/1ps
module ext_bus_seq_test;

    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic [7:0]    cfg_wdata;
    logic          bus16_mode;
    logic          wr_hold_en;
    logic          req_valid;
    logic          req_ready;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          req_word;
    logic          req_write;
    logic          done;
    logic [DW-1:0] rdata;
    logic          bus_ale, bus_rd, bus_wr, bus_doe;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_dout;
    logic [DW-1:0] bus_din;

    int checks = 0;
    int errors = 0;
    logic [7:0] cur_tim;

    always #2 clk = ~clk;

    // memory model: data derived from the address
    assign bus_din = {~bus_addr[7:0], bus_addr[7:0] ^ 8'hC3};

    ext_bus_seq #(.AW(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .bus16_mode(bus16_mode), .wr_hold_en(wr_hold_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_word(req_word), .req_write(req_write),
        .done(done), .rdata(rdata), .bus_ale(bus_ale), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .bus_din(bus_din)
    );

    task automatic check1(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [7:0] a);
        return a ^ 8'hC3;
    endfunction

    task automatic run(input string tag, input bit word, input bit write,
                       input bit b16, input bit hold, input bit load,
                       input logic [7:0] tim, input logic [7:0] a,
                       input logic [15:0] wd, input bit mid,
                       input logic [7:0] mid_tim);
        int la, n2, h, s, first, total;
        bit wide, bad;
        string msg;
        logic [15:0] exp_rd;
        if (load) begin
            cfg_we = 1'b1; cfg_wdata = tim;
            @(negedge clk);
            cfg_we = 1'b0;
            cur_tim = tim;
        end
        wide = word && b16;
        s    = (word && !b16) ? 1 : 0;
        h    = (hold && write) ? 1 : 0;
        la   = write ? int'(cur_tim[5:4]) + 2 : int'(cur_tim[1:0]) + 2;
        n2   = write ? int'(cur_tim[7:6]) + 2 : int'(cur_tim[3:2]) + 1;
        first = la + h;
        total = first + s * (n2 + h);
        if (wide)   exp_rd = {~a, mem_byte(a)};
        else if (s != 0) exp_rd = {mem_byte({a[7:1], 1'b1}), mem_byte({a[7:1], 1'b0})};
        else        exp_rd = {8'h00, mem_byte(a)};
        bus16_mode = b16; wr_hold_en = hold;
        req_valid = 1'b1; req_word = word; req_write = write;
        req_addr = a; req_wdata = wd;
        bad = (req_ready !== 1'b1);
        msg = bad ? "ready low at request" : "";
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k <= total; k++) begin
            logic e_ale, e_stb, e_hold, e_doe, e_rdy, e_done;
            logic [7:0]  e_addr;
            logic [15:0] e_dout;
            bit sec;
            sec    = (k >= first) && (k < total);
            e_ale  = (k == 0);
            if (k < first) begin
                e_stb  = (k >= 1) && (k < la);
                e_hold = (h != 0) && (k == la);
            end else if (k < total) begin
                e_stb  = (k - first) < n2;
                e_hold = (h != 0) && ((k - first) == n2);
            end else begin
                e_stb = 1'b0; e_hold = 1'b0;
            end
            e_doe  = write && (e_stb || e_hold);
            e_rdy  = (k == total);
            e_done = (k == total);
            e_addr = (k < total) ? ((s != 0) ? {a[7:1], sec} : a) : 8'h00;
            if (!e_doe)     e_dout = 16'h0;
            else if (wide)  e_dout = wd;
            else            e_dout = {8'h00, sec ? wd[15:8] : wd[7:0]};
            if (!bad && ({bus_ale, bus_rd, bus_wr, bus_doe, bus_addr, bus_dout, req_ready, done} !==
                         {e_ale, e_stb && !write, e_stb && write, e_doe, e_addr, e_dout, e_rdy, e_done})) begin
                bad = 1'b1;
                msg = $sformatf("k=%0d ale/rd/wr/doe=%b%b%b%b addr=%h dout=%h rdy=%b done=%b exp %b%b%b%b %h %h %b %b",
                    k, bus_ale, bus_rd, bus_wr, bus_doe, bus_addr, bus_dout, req_ready, done,
                    e_ale, e_stb && !write, e_stb && write, e_doe, e_addr, e_dout, e_rdy, e_done);
            end
            if (k == total && !write && !bad && rdata !== exp_rd) begin
                bad = 1'b1;
                msg = $sformatf("rdata actual=%h expected=%h", rdata, exp_rd);
            end
            if (mid && k == 1) begin
                cfg_we = 1'b1; cfg_wdata = mid_tim;
            end
            if (mid && k == 2) begin
                cfg_we = 1'b0; cur_tim = mid_tim;
            end
            if (k < total) @(negedge clk);
        end
        checks++;
        if (bad) begin
            errors++;
            $display("FAIL %s word=%0d wr=%0d b16=%0d hold=%0d tim=%h addr=%h: %s",
                     tag, word, write, b16, hold, cur_tim, a, msg);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R9 watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '0; bus16_mode = 1'b0;
        wr_hold_en = 1'b0; req_valid = 1'b0; req_addr = '0; req_wdata = '0;
        req_word = 1'b0; req_write = 1'b0; cur_tim = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check1("R1 ready", {31'b0, req_ready}, 32'd1);
        check1("R1 strobes", {28'b0, bus_ale, bus_rd, bus_wr, bus_doe}, 32'd0);
        check1("R1 done", {31'b0, done}, 32'd0);
        check1("R1 addr/dout", {bus_addr, bus_dout}, 32'd0);
        // R1 default slowest timing without loading the register
        run("R1 default timing read", 1, 0, 0, 0, 0, 8'hFF, 8'h40, 16'h0, 0, 8'h0);
        run("R1 default timing write", 1, 1, 0, 0, 0, 8'hFF, 8'h41, 16'hBEEF, 0, 8'h0);
        // R2 / R10: ALE read lengths, 16-bit mode, tail codes vary and must not matter
        for (int c = 0; c < 4; c++)
            for (int t = 0; t < 4; t++)
                run("R2 R10 wide read", 1, 0, 1, 0, 1, {t[1:0], 2'b01, t[1:0], c[1:0]},
                    8'h10 + 8'(c * 4 + t), 16'h0, 0, 8'h0);
        // R3 / R10: ALE write lengths, 16-bit mode
        for (int c = 0; c < 4; c++)
            for (int t = 0; t < 4; t++)
                run("R3 R10 wide write", 1, 1, 1, t[0], 1, {t[1:0], c[1:0], t[1:0], 2'b10},
                    8'h30 + 8'(c * 4 + t), 16'hA500 + 16'(c * 16 + t), 0, 8'h0);
        // R4 / R6: split reads, full cross of ALE and tail codes
        for (int c = 0; c < 4; c++)
            for (int t = 0; t < 4; t++)
                run("R4 R6 split read", 1, 0, 0, 1, 1, {2'b00, 2'b11, t[1:0], c[1:0]},
                    8'h80 + 8'(c * 8 + t * 2), 16'h0, 0, 8'h0);
        // R5 / R6 / R8: split writes with and without extra hold
        for (int c = 0; c < 4; c++)
            for (int t = 0; t < 4; t++)
                for (int hd = 0; hd < 2; hd++)
                    run("R5 R8 split write", 1, 1, 0, hd[0], 1, {t[1:0], c[1:0], 2'b10, 2'b01},
                        8'hA0 + 8'(c * 4 + t), 16'h1234 + 16'(c * 256 + t * 17 + hd), 0, 8'h0);
        // R6: odd request address in 8-bit mode
        run("R6 odd addr read", 1, 0, 0, 0, 1, 8'h5A, 8'h77, 16'h0, 0, 8'h0);
        run("R6 odd addr write", 1, 1, 0, 0, 1, 8'h5A, 8'hE3, 16'hC0DE, 0, 8'h0);
        // R10: byte accesses in both modes
        for (int m = 0; m < 2; m++)
            for (int w = 0; w < 2; w++)
                for (int hd = 0; hd < 2; hd++)
                    run("R10 byte access", 0, w[0], m[0], hd[0], 1, 8'h96 ^ 8'(m * 2 + w),
                        8'h51 + 8'(m * 4 + w * 2 + hd), 16'hFE37, 0, 8'h0);
        // R8: hold flag ignored for reads
        run("R8 hold on read", 1, 0, 0, 1, 1, 8'h00, 8'h22, 16'h0, 0, 8'h0);
        // R11: timing change during a transfer
        run("R11 mid-transfer cfg write", 1, 0, 0, 0, 1, 8'hFF, 8'h64, 16'h0, 1, 8'h00);
        run("R11 new cfg applies next", 1, 0, 0, 0, 0, 8'h00, 8'h66, 16'h0, 0, 8'h0);
        run("R11 mid-transfer cfg write wr", 1, 1, 0, 1, 1, 8'h00, 8'h68, 16'h4321, 1, 8'hFF);
        run("R11 new cfg applies next wr", 1, 1, 0, 1, 0, 8'hFF, 8'h6A, 16'h8765, 0, 8'h0);
        // R9: done drops after one clock
        @(negedge clk);
        check1("R9 done single pulse", {31'b0, done}, 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    end

endmodule